// File: doc/BRIEF.md
# Command-Driven Serial Bridge Controller

This block links a host that speaks in fixed seven-byte commands to a small peripheral board. The host presents one byte per cycle with a valid strobe: a command byte, a subfunction byte and five parameter bytes. The block decodes the frame and does one of two jobs. It can run a full-duplex five-byte exchange over a three-wire serial port that it clocks as master. It can also set a sticky level output that picks which of two audio/video sources the board routes onward.

Every command, whether accepted or rejected, is answered with six response bytes on consecutive cycles. The first is a status byte and five data bytes follow. A busy flag covers the whole span from frame completion to the last response byte, and host bytes that arrive during that span are dropped. The serial clock rate comes from a divider parameter.

Top module: `sbr_bridge`

## Requirements
- R1: A frame is seven host bytes taken on cycles with `host_valid` high. Only command 0x1F with subfunction 0x01 or 0x02 is valid. Any other frame is answered with status 0x01 ORed with the mode level in bit 1, followed by five 0x00 bytes. A rejected frame causes no serial clock activity and leaves `src_sel` unchanged.
- R2: Subfunction 0x01 sends the five parameter bytes on `ser_out`, first parameter first and MSB first, for 40 bits with no gaps. `ser_clk` idles low. `ser_out` changes only while `ser_clk` falls. `ser_in` is sampled as `ser_clk` rises.
- R3: The response to subfunction 0x01 is the status byte, then the five bytes captured from `ser_in`, in the order they were received.
- R4: Subfunction 0x02 reads only parameter byte 0. A value of 0x00 drives `src_sel` low, and any value from 0x01 to 0xFF drives it high. The other four parameters have no effect. The response is the status byte followed by five 0x00 bytes.
- R5: `src_sel` is low after reset and changes only when a valid subfunction 0x02 frame completes.
- R6: The status byte has bit 1 equal to the `src_sel` level once the command has taken effect, and bit 0 equal to the error flag. Bits 7 to 2 are zero.
- R7: The six response bytes appear on six consecutive cycles with `resp_valid` high. `busy` is high from the cycle after the seventh host byte through the last response byte, and low on the cycle after that.
- R8: Host bytes presented while `busy` is high are ignored and do not become part of any later frame.
- R9: Each high phase and each low phase of `ser_clk` lasts CLK_DIV/2 system clocks, so one transfer holds `ser_clk` high for 40 x CLK_DIV/2 clocks in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host byte strobe |
| host_byte | input | 8 | Host command or parameter byte |
| busy | output | 1 | Command in progress; host bytes are ignored |
| resp_valid | output | 1 | Response byte strobe |
| resp_byte | output | 8 | Response byte (status first) |
| ser_clk | output | 1 | Serial clock, master driven, idles low |
| ser_out | output | 1 | Serial data to the peripheral |
| ser_in | input | 1 | Serial data from the peripheral |
| src_sel | output | 1 | Sticky source-select level |

## Verification
A collector that loses its byte position would misread the next frame. That shows up within one command, as a rejected status or shifted response bytes, so the bench sends stray bytes during a transfer and then checks the frame that follows. A wrong bit counter or divider in the shift engine shows up at the end of a transfer, as a rising-edge count other than 40, a high-time total other than 40 x CLK_DIV/2 clocks, or misplaced bits in the captured bytes. A bad mode register shows up on the `src_sel` pin and in status bit 1 of the very next response. A faulty reply sequencer shows up in the same response, as a gap in `resp_valid` or a `busy` that stays high too long.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam logic [7:0] CMD_BRIDGE = 8'h1F;
  localparam logic [7:0] SUB_XFER   = 8'h01;
  localparam logic [7:0] SUB_MODE   = 8'h02;

  typedef enum logic [1:0] {
    OP_XFER = 2'd0,
    OP_MODE = 2'd1,
    OP_BAD  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_SHIFT   = 2'd1,
    ST_REPLY   = 2'd2
  } st_e;

  // Map command and subfunction to an operation.
  function automatic op_e classify(input logic [7:0] cmd, input logic [7:0] sub);
    if (cmd != CMD_BRIDGE)   return OP_BAD;
    else if (sub == SUB_XFER) return OP_XFER;
    else if (sub == SUB_MODE) return OP_MODE;
    else                      return OP_BAD;
  endfunction

  // Status layout: bit1 = source level, bit0 = error.
  function automatic logic [7:0] status_byte(input logic level, input logic err);
    return {6'b0, level, err};
  endfunction

endpackage

// File: rtl/sbr_collect.sv
module sbr_collect #(
  parameter int FRAME_LEN = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept_en,
  input  logic                      in_valid,
  input  logic [7:0]                in_byte,
  output logic [FRAME_LEN-1:0][7:0] frame_o,
  output logic                      done_o
);
  localparam int IDXW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_LEN - 1);

  logic [IDXW-1:0] idx_q;
  logic            take;

  assign take = accept_en && in_valid && !done_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      done_o  <= 1'b0;
      frame_o <= '0;
    end else begin
      done_o <= take && (idx_q == LAST_IDX);
      if (take) begin
        frame_o[idx_q] <= in_byte;
        if (idx_q == LAST_IDX) idx_q <= '0;
        else                   idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbr_shift.sv
module sbr_shift #(
  parameter int NBYTES  = 5,
  parameter int CLK_DIV = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [NBYTES-1:0][7:0] tx_i,
  input  logic                   miso_i,
  output logic                   sclk_o,
  output logic                   mosi_o,
  output logic [NBYTES-1:0][7:0] rx_o,
  output logic                   active_o,
  output logic                   done_o
);
  localparam int NBITS = NBYTES * 8;
  localparam int HALF  = CLK_DIV / 2;
  localparam int CW    = $clog2(CLK_DIV);
  localparam int BW    = $clog2(NBITS);
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(CLK_DIV - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

  logic [NBITS-1:0] tx_sr;
  logic [NBITS-1:0] rx_sr;
  logic [CW-1:0]    cnt_q;
  logic [BW-1:0]    bit_q;
  logic             rise_evt;
  logic             fall_evt;

  assign rise_evt = active_o && (cnt_q == RISE_AT);
  assign fall_evt = active_o && (cnt_q == FALL_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      cnt_q    <= '0;
      bit_q    <= '0;
      sclk_o   <= 1'b0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active_o) begin
        active_o <= 1'b1;
        tx_sr    <= tx_i;
        rx_sr    <= '0;
        cnt_q    <= '0;
        bit_q    <= '0;
        sclk_o   <= 1'b0;
      end else if (active_o) begin
        if (rise_evt) begin
          sclk_o <= 1'b1;
          rx_sr  <= {rx_sr[NBITS-2:0], miso_i};
          cnt_q  <= cnt_q + 1'b1;
        end else if (fall_evt) begin
          sclk_o <= 1'b0;
          cnt_q  <= '0;
          if (bit_q == LAST_BIT) begin
            active_o <= 1'b0;
            done_o   <= 1'b1;
          end else begin
            tx_sr <= {tx_sr[NBITS-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mosi_o = active_o && tx_sr[NBITS-1];
  assign rx_o   = rx_sr;

endmodule

// File: rtl/sbr_reply.sv
module sbr_reply #(
  parameter int LEN = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [LEN-1:0][7:0] data_i,
  output logic                valid_o,
  output logic [7:0]          byte_o,
  output logic                last_o
);
  localparam int IW = $clog2(LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(LEN - 1);

  logic [LEN-1:0][7:0] buf_q;
  logic [IW-1:0]       idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      idx_q   <= '0;
      valid_o <= 1'b0;
    end else if (load_i && !valid_o) begin
      buf_q   <= data_i;
      idx_q   <= '0;
      valid_o <= 1'b1;
    end else if (valid_o) begin
      if (idx_q == LAST_IDX) begin
        valid_o <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign byte_o = valid_o ? buf_q[idx_q] : 8'h00;
  assign last_o = valid_o && (idx_q == LAST_IDX);

endmodule

// File: rtl/sbr_bridge.sv
module sbr_bridge
  import sbr_pkg::*;
#(
  parameter int PARAM_BYTES = 5,
  parameter int CLK_DIV     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_valid,
  input  logic [7:0] host_byte,
  output logic       busy,
  output logic       resp_valid,
  output logic [7:0] resp_byte,
  output logic       ser_clk,
  output logic       ser_out,
  input  logic       ser_in,
  output logic       src_sel
);
  localparam int FRAME_LEN = PARAM_BYTES + 2;
  localparam int REPLY_LEN = PARAM_BYTES + 1;

  st_e  state_q;
  logic mode_q;
  op_e  op;

  logic [FRAME_LEN-1:0][7:0]   frame;
  logic                        col_done;
  logic [PARAM_BYTES-1:0][7:0] tx_word;
  logic [PARAM_BYTES-1:0][7:0] rx_word;
  logic [PARAM_BYTES-1:0][7:0] rx_ordered;
  logic [REPLY_LEN-1:0][7:0]   reply_data;

  // Named internal events, also used by the checker.
  logic sh_start;
  logic sh_active;
  logic sh_done;
  logic mode_wr;
  logic reply_load;
  logic resp_last;

  sbr_collect #(.FRAME_LEN(FRAME_LEN)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en (state_q == ST_COLLECT),
    .in_valid  (host_valid),
    .in_byte   (host_byte),
    .frame_o   (frame),
    .done_o    (col_done)
  );

  assign op = classify(frame[0], frame[1]);

  genvar gi;
  generate
    for (gi = 0; gi < PARAM_BYTES; gi++) begin : g_map
      assign tx_word[PARAM_BYTES-1-gi] = frame[2+gi];
      assign rx_ordered[gi]            = rx_word[PARAM_BYTES-1-gi];
    end
  endgenerate

  assign sh_start = col_done && (op == OP_XFER);
  assign mode_wr  = col_done && (op == OP_MODE);

  sbr_shift #(.NBYTES(PARAM_BYTES), .CLK_DIV(CLK_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (sh_start),
    .tx_i     (tx_word),
    .miso_i   (ser_in),
    .sclk_o   (ser_clk),
    .mosi_o   (ser_out),
    .rx_o     (rx_word),
    .active_o (sh_active),
    .done_o   (sh_done)
  );

  always_comb begin
    reply_data = '0;
    if (state_q == ST_SHIFT) begin
      reply_data[0] = status_byte(mode_q, 1'b0);
      for (int i = 0; i < PARAM_BYTES; i++) reply_data[1+i] = rx_ordered[i];
    end else if (op == OP_MODE) begin
      reply_data[0] = status_byte(|frame[2], 1'b0);
    end else begin
      reply_data[0] = status_byte(mode_q, 1'b1);
    end
  end

  assign reply_load = (col_done && (op != OP_XFER)) || (state_q == ST_SHIFT && sh_done);

  sbr_reply #(.LEN(REPLY_LEN)) u_reply (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (reply_load),
    .data_i  (reply_data),
    .valid_o (resp_valid),
    .byte_o  (resp_byte),
    .last_o  (resp_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      mode_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= |frame[2];
      unique case (state_q)
        ST_COLLECT: if (col_done) state_q <= (op == OP_XFER) ? ST_SHIFT : ST_REPLY;
        ST_SHIFT:   if (sh_done)  state_q <= ST_REPLY;
        ST_REPLY:   if (resp_last) state_q <= ST_COLLECT;
        default:    state_q <= ST_COLLECT;
      endcase
    end
  end

  assign busy    = (state_q != ST_COLLECT) || col_done;
  assign src_sel = mode_q;

endmodule

// File: rtl/sbr_chk.sv
module sbr_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic resp_valid,
  input logic resp_last,
  input logic ser_clk,
  input logic src_sel,
  input logic sh_active,
  input logic mode_wr,
  input logic col_done
);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_active |-> !ser_clk);

  // R7
  reply_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> busy);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_last |=> !busy);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_done |=> busy);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(src_sel));

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_active, resp_valid}));

endmodule

bind sbr_bridge sbr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .resp_valid (resp_valid),
  .resp_last  (resp_last),
  .ser_clk    (ser_clk),
  .src_sel    (src_sel),
  .sh_active  (sh_active),
  .mode_wr    (mode_wr),
  .col_done   (col_done)
);

// File: tb/sbr_bridge_tb.sv
`timescale 1ns/1ps
module sbr_bridge_tb;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic [7:0] host_byte = 8'h00;
  logic       busy, resp_valid, ser_clk, ser_out, ser_in, src_sel;
  logic [7:0] resp_byte;

  always #4 clk = ~clk;

  sbr_bridge #(.PARAM_BYTES(5), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
    .busy(busy), .resp_valid(resp_valid), .resp_byte(resp_byte),
    .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in), .src_sel(src_sel)
  );

  // Peripheral model: shifts the pattern out on falling edges, captures on rising.
  logic [39:0] slave_pat = 40'h0;
  logic [39:0] slave_rx = 40'h0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  int hi_cnt = 0;

  always @(posedge ser_clk) begin
    slave_rx <= {slave_rx[38:0], ser_out};
    rise_cnt <= rise_cnt + 1;
  end
  always @(negedge ser_clk) fall_cnt <= fall_cnt + 1;
  always @(posedge clk) if (ser_clk) hi_cnt <= hi_cnt + 1;
  always_comb ser_in = slave_pat[39 - (fall_cnt % 40)];

  // Scoreboard.
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int n_checks = 0, n_fails = 0;
  int m_checks = 0, m_fails = 0;

  always @(negedge clk) begin : monitor
    logic [7:0] e;
    string t;
    if (rst_n && resp_valid) begin
      m_checks = m_checks + 1;
      if (exp_q.size() == 0) begin
        m_fails = m_fails + 1;
        $display("FAIL unexpected response byte: actual %02h expected none", resp_byte);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (resp_byte !== e) begin
          m_fails = m_fails + 1;
          $display("FAIL %s response byte: actual %02h expected %02h", t, resp_byte, e);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Send one seven-byte frame {b0..b6}; expect six bytes {r0..r5}.
  task automatic do_frame(input logic [55:0] f, input logic [47:0] r,
                          input string tag, input bit junk);
    for (int i = 0; i < 6; i++) begin
      exp_q.push_back(r[47-8*i -: 8]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      host_valid = 1'b1;
      host_byte  = f[55-8*i -: 8];
    end
    @(negedge clk);
    host_valid = 1'b0;
    check(busy === 1'b1, "R7 busy after frame", int'(busy), 1);
    if (junk) begin
      // R8: stray bytes while busy must be dropped
      for (int k = 0; k < 3; k++) begin
        host_valid = 1'b1;
        host_byte  = (k == 0) ? 8'h1F : 8'h02;
        @(negedge clk);
      end
      host_valid = 1'b0;
    end
    while (!resp_valid) @(negedge clk);
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      check(resp_valid === 1'b1, "R7 consecutive bytes", int'(resp_valid), 1);
    end
    @(negedge clk);
    check(busy === 1'b0, "R7 busy release", int'(busy), 0);
    check(exp_q.size() == 0, "R7 byte count", exp_q.size(), 0);
  endtask

  task automatic run_xfer(input logic [39:0] tx, input logic [39:0] pat,
                          input logic lvl, input string tag, input bit junk);
    int r0, h0;
    slave_pat = pat;
    r0 = rise_cnt;
    h0 = hi_cnt;
    do_frame({8'h1F, 8'h01, tx}, {6'b0, lvl, 1'b0, pat}, tag, junk);
    check(rise_cnt - r0 == 40, "R2 rising edges", rise_cnt - r0, 40);
    check(hi_cnt - h0 == 40 * (DIV / 2), "R9 clock high time", hi_cnt - h0, 40 * (DIV / 2));
    check(slave_rx == tx, "R2 serial out bits", int'(slave_rx[31:0]), int'(tx[31:0]));
  endtask

  task automatic run_plain(input logic [55:0] f, input logic [7:0] st,
                           input logic lvl, input string tag);
    int r0;
    r0 = rise_cnt;
    do_frame(f, {st, 40'h0}, tag, 1'b0);
    check(rise_cnt == r0, {tag, " no serial clock"}, rise_cnt - r0, 0);
    check(src_sel === lvl, {tag, " source level"}, int'(src_sel), int'(lvl));
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_checks + m_checks, n_fails + m_fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual timeout expected completion");
    n_fails = n_fails + 1;
    n_checks = n_checks + 1;
    report();
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check(src_sel === 1'b0, "R5 reset level", int'(src_sel), 0);
    check(busy === 1'b0, "R7 reset busy", int'(busy), 0);
    check(ser_clk === 1'b0, "R2 reset clock idle", int'(ser_clk), 0);
    check(resp_valid === 1'b0, "R7 reset response idle", int'(resp_valid), 0);

    // R4 zero parameter selects normal source; R6 status 0x00
    run_plain({8'h1F, 8'h02, 8'h00, 32'hDEADBEEF}, 8'h00, 1'b0, "R4 mode zero");
    // R4 nonzero selects alternate; R6 status 0x02
    run_plain({8'h1F, 8'h02, 8'h5A, 32'h00000000}, 8'h02, 1'b1, "R4 mode 5A");
    // R3 exchange with stray bytes during busy (R8)
    run_xfer(40'hA53CFF0081, 40'h123456789A, 1'b1, "R3 R8 exchange one", 1'b1);
    // R1 bad command code, mode stays high (R5)
    run_plain({8'h20, 8'h01, 40'h1111111111}, 8'h03, 1'b1, "R1 bad command");
    // R1 bad subfunction
    run_plain({8'h1F, 8'h03, 40'hFFFFFFFFFF}, 8'h03, 1'b1, "R1 bad sub 03");
    // R4 boundary values
    run_plain({8'h1F, 8'h02, 8'h01, 32'h0}, 8'h02, 1'b1, "R4 mode 01");
    run_plain({8'h1F, 8'h02, 8'hFF, 32'h0}, 8'h02, 1'b1, "R4 mode FF");
    run_plain({8'h1F, 8'h02, 8'h00, 32'hFFFFFFFF}, 8'h00, 1'b0, "R6 mode back low");
    // R3 second exchange with low source
    run_xfer(40'h00FF55AA01, 40'hFF00C33C80, 1'b0, "R3 exchange two", 1'b0);
    // R1 subfunction zero with low source: status 0x01
    run_plain({8'h1F, 8'h00, 40'h0}, 8'h01, 1'b0, "R1 bad sub 00");
    run_xfer(40'h8001FE7F10, 40'h0102040810, 1'b0, "R2 exchange three", 1'b0);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule